// File: doc/BRIEF.md
# Conditional Flag Set and Bit-Transfer Unit

This unit evaluates a 4-bit condition code against the four processor status flags (carry C, zero Z, sign S, overflow O) and folds the true/false result into a destination operand. In bit-transfer mode it writes the result into one chosen bit of the old destination value and keeps every other bit. In set mode it overwrites the operand with the value 0 or 1, zero-extended to a byte, word or long operand.

The same write-back path serves register and memory destinations. The `mem_dst` input only narrows the bit index to the range of a byte held in memory. A request presented with `in_valid` produces the new destination value, `out_valid` and, for the reserved condition code, an `illegal` flag one clock later. The asynchronous active-low reset is released inside the unit through a two-stage synchronizer, so requests are accepted from the third rising edge after `rst_n` goes high.

Top module: `cond_xfer_unit`

## Requirements
- R1: The condition codes decode as 0 eq (Z), 1 ne (!Z), 2 geu (C), 3 ltu (!C), 4 gtu (C&!Z), 5 leu (!(C&!Z)), 6 pz (!S), 7 n (S), 8 ge (!(S^O)), 9 lt (S^O), 10 gt (!((S^O)|Z)), 11 le ((S^O)|Z), 12 o (O) and 13 no (!O).
- R2: When `mode`=0 (bit transfer) and `mem_dst`=0, bit `bit_idx` (0..31) of `dst_new` takes the condition result, and every other bit equals `dst_old`.
- R3: When `mode`=0 and `mem_dst`=1, only `bit_idx[2:0]` selects the bit, so `bit_idx[4:3]` has no effect and bits 31..8 equal `dst_old`.
- R4: When `mode`=1 (set) and `size`=2 (long), `dst_new` is 32'd1 if the condition holds and 32'd0 otherwise.
- R5: When `mode`=1 and `size`=0 (byte) or 1 (word), the low 8 or 16 bits become the zero-extended result and the bits above keep `dst_old`. `size`=3 behaves as long.
- R6: Code 14 is always true. Code 15 is reserved: it sets `illegal` and returns `dst_new` equal to `dst_old` in both modes.
- R7: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. `illegal` is high only together with `out_valid`.
- R8: While `in_valid` is low, `dst_new` holds its last value and the inputs have no effect.
- R9: During reset and after it, until the first request, `out_valid`=0, `illegal`=0 and `dst_new`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_o | input | 1 | Overflow flag |
| cond | input | 4 | Condition code |
| mode | input | 1 | 0 bit transfer, 1 set |
| mem_dst | input | 1 | Destination is a byte in memory |
| bit_idx | input | 5 | Bit index for bit transfer |
| size | input | 2 | Set-mode size: 0 byte, 1 word, 2/3 long |
| dst_old | input | 32 | Previous destination value |
| out_valid | output | 1 | Result strobe |
| dst_new | output | 32 | New destination value |
| illegal | output | 1 | Reserved condition code used |

## Verification
A wrong condition decode shows as a flipped bit 0 of `dst_new` in set mode one cycle after the request. A sweep of every code against all sixteen flag combinations exposes it on the first flag pattern it mishandles. A faulty index or mask in the bit-transfer path corrupts a neighbouring bit, or one above bit 7 for memory operands, in that same output word. A broken clock enable or valid pipeline shows as `dst_new` moving, or `out_valid` staying high, in the cycle after `in_valid` falls.

// File: rtl/cxu_pkg.sv
package cxu_pkg;

  typedef enum logic [3:0] {
    CC_EQ  = 4'd0,  CC_NE  = 4'd1,  CC_GEU = 4'd2,  CC_LTU = 4'd3,
    CC_GTU = 4'd4,  CC_LEU = 4'd5,  CC_PZ  = 4'd6,  CC_N   = 4'd7,
    CC_GE  = 4'd8,  CC_LT  = 4'd9,  CC_GT  = 4'd10, CC_LE  = 4'd11,
    CC_O   = 4'd12, CC_NO  = 4'd13, CC_AL  = 4'd14, CC_RSV = 4'd15
  } cc_e;

  typedef enum logic {
    WB_BIT = 1'b0,
    WB_SET = 1'b1
  } wb_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_ALT  = 2'd3
  } opsize_e;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic o;
  } flags_t;

endpackage

// File: rtl/cxu_rst_sync.sv
module cxu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cxu_cond_eval.sv
module cxu_cond_eval
  import cxu_pkg::*;
(
  input  logic [3:0] cond,
  input  flags_t     flags,
  output logic       taken,
  output logic       reserved
);
  logic sxo;
  logic hi;

  always_comb begin
    sxo = flags.s ^ flags.o;
    hi  = flags.c & ~flags.z;
    reserved = 1'b0;
    unique case (cc_e'(cond))
      CC_EQ:  taken = flags.z;
      CC_NE:  taken = ~flags.z;
      CC_GEU: taken = flags.c;
      CC_LTU: taken = ~flags.c;
      CC_GTU: taken = hi;
      CC_LEU: taken = ~hi;
      CC_PZ:  taken = ~flags.s;
      CC_N:   taken = flags.s;
      CC_GE:  taken = ~sxo;
      CC_LT:  taken = sxo;
      CC_GT:  taken = ~(sxo | flags.z);
      CC_LE:  taken = sxo | flags.z;
      CC_O:   taken = flags.o;
      CC_NO:  taken = ~flags.o;
      CC_AL:  taken = 1'b1;
      default: begin
        taken    = 1'b0;
        reserved = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/cxu_writeback.sv
module cxu_writeback
  import cxu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int WORD_W  = 16,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int BIDX_W = $clog2(BYTE_W)
) (
  input  logic              mode,
  input  logic              mem_dst,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] dst_old,
  input  logic              taken,
  input  logic              reserved,
  output logic [DATA_W-1:0] dst_next
);
  logic [IDX_W-1:0]  eff_idx;
  logic [DATA_W-1:0] ins_val;
  logic [DATA_W-1:0] set_val;
  logic [DATA_W-1:0] res_word;

  always_comb begin
    if (mem_dst) eff_idx = {{(IDX_W-BIDX_W){1'b0}}, bit_idx[BIDX_W-1:0]};
    else         eff_idx = bit_idx;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_ins
    assign ins_val[i] = (eff_idx == IDX_W'(i)) ? taken : dst_old[i];
  end

  always_comb begin
    res_word = {{(DATA_W-1){1'b0}}, taken};
    unique case (opsize_e'(size))
      SZ_BYTE: set_val = {dst_old[DATA_W-1:BYTE_W], res_word[BYTE_W-1:0]};
      SZ_WORD: set_val = {dst_old[DATA_W-1:WORD_W], res_word[WORD_W-1:0]};
      default: set_val = res_word;
    endcase
  end

  always_comb begin
    if (reserved)                   dst_next = dst_old;
    else if (wb_mode_e'(mode) == WB_SET) dst_next = set_val;
    else                            dst_next = ins_val;
  end
endmodule

// File: rtl/cxu_out_reg.sv
module cxu_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] dst_next,
  input  logic              illegal_next,
  output logic              valid_q,
  output logic [DATA_W-1:0] dst_q,
  output logic              illegal_q
);
  logic [DATA_W-1:0] dst_d;
  logic              valid_d;
  logic              illegal_d;

  always_comb begin
    dst_d     = en ? dst_next : dst_q;
    valid_d   = en;
    illegal_d = en & illegal_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q     <= '0;
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      dst_q     <= dst_d;
      valid_q   <= valid_d;
      illegal_q <= illegal_d;
    end
  end
endmodule

// File: rtl/cond_xfer_unit.sv
module cond_xfer_unit
  import cxu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              flag_c,
  input  logic              flag_z,
  input  logic              flag_s,
  input  logic              flag_o,
  input  logic [3:0]        cond,
  input  logic              mode,
  input  logic              mem_dst,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] dst_old,
  output logic              out_valid,
  output logic [DATA_W-1:0] dst_new,
  output logic              illegal
);
  logic              rst_sync_n;
  flags_t            flags;
  logic              taken;
  logic              reserved;
  logic [DATA_W-1:0] dst_next;

  assign flags = '{c: flag_c, z: flag_z, s: flag_s, o: flag_o};

  cxu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cxu_cond_eval u_eval (
    .cond(cond), .flags(flags), .taken(taken), .reserved(reserved)
  );

  cxu_writeback #(.DATA_W(DATA_W)) u_wb (
    .mode(mode), .mem_dst(mem_dst), .bit_idx(bit_idx), .size(size),
    .dst_old(dst_old), .taken(taken), .reserved(reserved),
    .dst_next(dst_next)
  );

  cxu_out_reg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst_n(rst_sync_n), .en(in_valid),
    .dst_next(dst_next), .illegal_next(reserved),
    .valid_q(out_valid), .dst_q(dst_new), .illegal_q(illegal)
  );
endmodule

// File: rtl/cxu_checker.sv
module cxu_checker #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              in_valid,
  input logic [3:0]        cond,
  input logic              mode,
  input logic              mem_dst,
  input logic [IDX_W-1:0]  bit_idx,
  input logic [1:0]        size,
  input logic [DATA_W-1:0] dst_old,
  input logic              out_valid,
  input logic [DATA_W-1:0] dst_new,
  input logic              illegal
);
  logic [DATA_W-1:0] sel_mask;
  assign sel_mask = mem_dst ? (DATA_W'(1) << bit_idx[2:0]) : (DATA_W'(1) << bit_idx);

  // R2
  a_r2_others_kept: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !mode && cond != 4'hF) |=>
      (((dst_new ^ $past(dst_old)) & ~$past(sel_mask)) == '0));

  // R3
  a_r3_mem_upper_kept: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !mode && mem_dst) |=> (dst_new[DATA_W-1:8] == $past(dst_old[DATA_W-1:8])));

  // R4
  a_r4_set_long_zero_ext: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && mode && size == 2'd2 && cond != 4'hF) |=> (dst_new[DATA_W-1:1] == '0));

  // R6
  a_r6_reserved_keeps: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && cond == 4'hF) |=> (illegal && dst_new == $past(dst_old)));

  a_r6_always_true: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && mode && cond == 4'hE) |=> dst_new[0]);

  // R7
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid);

  a_r7_valid_drops: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !out_valid);

  a_r7_illegal_qualified: assert property (@(posedge clk) disable iff (!rst_ok)
    illegal |-> out_valid);

  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> $stable(dst_new));
endmodule

bind cond_xfer_unit cxu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .in_valid(in_valid), .cond(cond),
  .mode(mode), .mem_dst(mem_dst), .bit_idx(bit_idx), .size(size),
  .dst_old(dst_old), .out_valid(out_valid), .dst_new(dst_new),
  .illegal(illegal)
);

// File: tb/cond_xfer_unit_tb.sv
`timescale 1ns/1ps
module cond_xfer_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        fc, fz, fs, fo;
  logic [3:0]  cond;
  logic        mode, mem_dst;
  logic [4:0]  bit_idx;
  logic [1:0]  size;
  logic [31:0] dst_old;
  logic        out_valid, illegal;
  logic [31:0] dst_new;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cond_xfer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .flag_c(fc), .flag_z(fz), .flag_s(fs), .flag_o(fo),
    .cond(cond), .mode(mode), .mem_dst(mem_dst), .bit_idx(bit_idx),
    .size(size), .dst_old(dst_old), .out_valid(out_valid),
    .dst_new(dst_new), .illegal(illegal)
  );

  function automatic logic spec_cond(input logic [3:0] cc, input logic c, z, s, o);
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return c && !z;
      4'd5:  return !(c && !z);
      4'd6:  return !s;
      4'd7:  return s;
      4'd8:  return s == o;
      4'd9:  return s != o;
      4'd10: return (s == o) && !z;
      4'd11: return (s != o) || z;
      4'd12: return o;
      4'd13: return !o;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one request at a negedge, sample at the following negedge
  task automatic issue(input logic [3:0] cc, input logic [3:0] fl, input logic md,
                       input logic mem, input logic [4:0] idx, input logic [1:0] sz,
                       input logic [31:0] old);
    in_valid = 1'b1; cond = cc; {fc, fz, fs, fo} = fl;
    mode = md; mem_dst = mem; bit_idx = idx; size = sz; dst_old = old;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check32("R9 out_valid", {31'd0, out_valid}, 32'd0);
    check32("R9 illegal", {31'd0, illegal}, 32'd0);
    check32("R9 dst_new", dst_new, 32'd0);
  endtask

  task automatic t_cond_sweep;
    for (int cc = 0; cc < 15; cc++) begin
      for (int f = 0; f < 16; f++) begin
        logic e;
        e = spec_cond(4'(cc), f[3], f[2], f[1], f[0]);
        issue(4'(cc), 4'(f), 1'b1, 1'b0, 5'd0, 2'd2, 32'hFFFF_FFFF);
        check32(cc == 14 ? "R6 always" : "R1/R4 cond set long", dst_new, {31'd0, e});
        check32("R7 valid", {31'd0, out_valid}, 32'd1);
      end
    end
  endtask

  task automatic t_bit_reg;
    logic [31:0] old;
    old = 32'hA5C3_0F96;
    for (int i = 0; i < 32; i += 5) begin
      issue(4'd14, 4'h0, 1'b0, 1'b0, 5'(i), 2'd0, old);
      check32("R2 bit set", dst_new, old | (32'd1 << i));
      issue(4'd0, 4'h0, 1'b0, 1'b0, 5'(i), 2'd0, old); // Z=0 -> eq false
      check32("R2 bit clear", dst_new, old & ~(32'd1 << i));
    end
    issue(4'd2, 4'h8, 1'b0, 1'b0, 5'd31, 2'd0, 32'h0);
    check32("R2 top bit", dst_new, 32'h8000_0000);
  endtask

  task automatic t_bit_mem;
    issue(4'd14, 4'h0, 1'b0, 1'b1, 5'd29, 2'd0, 32'h0000_0000);
    check32("R3 mem index masked", dst_new, 32'h0000_0020);
    issue(4'd1, 4'h4, 1'b0, 1'b1, 5'd15, 2'd0, 32'hFFFF_FFFF);
    check32("R3 mem clear low bits", dst_new, 32'hFFFF_FF7F);
  endtask

  task automatic t_set_sizes;
    issue(4'd14, 4'h0, 1'b1, 1'b0, 5'd0, 2'd0, 32'hDEAD_BEEF);
    check32("R5 byte true", dst_new, 32'hDEAD_BE01);
    issue(4'd7, 4'h0, 1'b1, 1'b0, 5'd0, 2'd1, 32'hDEAD_BEEF);
    check32("R5 word false", dst_new, 32'hDEAD_0000);
    issue(4'd14, 4'h0, 1'b1, 1'b0, 5'd0, 2'd3, 32'hDEAD_BEEF);
    check32("R5 size3 as long", dst_new, 32'h0000_0001);
    issue(4'd12, 4'h0, 1'b1, 1'b0, 5'd0, 2'd2, 32'hDEAD_BEEF);
    check32("R4 long false", dst_new, 32'h0000_0000);
  endtask

  task automatic t_reserved;
    issue(4'd15, 4'hF, 1'b1, 1'b0, 5'd3, 2'd2, 32'h1234_5678);
    check32("R6 reserved set keeps", dst_new, 32'h1234_5678);
    check32("R6 illegal", {31'd0, illegal}, 32'd1);
    issue(4'd15, 4'hF, 1'b0, 1'b0, 5'd3, 2'd2, 32'h8765_4321);
    check32("R6 reserved bit keeps", dst_new, 32'h8765_4321);
    issue(4'd14, 4'h0, 1'b1, 1'b0, 5'd0, 2'd2, 32'h0);
    check32("R7 illegal clears", {31'd0, illegal}, 32'd0);
  endtask

  task automatic t_idle_hold;
    issue(4'd14, 4'h0, 1'b1, 1'b0, 5'd0, 2'd2, 32'h0);
    cond = 4'd15; mode = 1'b0; dst_old = 32'hFFFF_0000; bit_idx = 5'd4;
    @(negedge clk);
    check32("R8 hold dst", dst_new, 32'h0000_0001);
    check32("R7 valid low", {31'd0, out_valid}, 32'd0);
    check32("R7 illegal low", {31'd0, illegal}, 32'd0);
    @(negedge clk);
    check32("R8 hold dst later", dst_new, 32'h0000_0001);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; {fc, fz, fs, fo} = 4'h0;
    cond = 4'd0; mode = 1'b0; mem_dst = 1'b0; bit_idx = 5'd0;
    size = 2'd0; dst_old = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_cond_sweep();
    t_bit_reg();
    t_bit_mem();
    t_set_sizes();
    t_reserved();
    t_idle_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule